// File: doc/BRIEF.md
# Reference clock qualification monitor

This block judges one incoming timing reference against the local master clock. The reference is brought into the master-clock domain through a two-flop synchronizer, and its rising edges are counted over a fixed gate of master-clock cycles. At the end of each gate the count is compared with the count a reference at exactly its nominal frequency would give. The difference is the frequency offset, expressed in edges per gate.

The offset drives an out-of-range flag through a two-limit window with hysteresis. Two coarse checks can disqualify the reference. The first is a missing edge, where the gap between edges grows beyond one and a half nominal periods. The second is a gross frequency error over a gate. Either one raises the fail flag and the holdover request toward the loop's mode logic at once. A requalify timer then holds both until the reference has stayed fault-free for a full requalify interval. The out-of-range flag is a status output only and never moves the loop into holdover.

All limits are parameters: the ppm thresholds, the gate length and the requalify interval, the last two in master-clock cycles. Each threshold becomes a count limit of floor(nominal × ppm / 1 000 000) for the selected rate.

Top module: `refmon`

## Requirements
- R1: While reset is active, and afterwards until the first gate of GATE_CYC master cycles has completed, `ref_fail`, `holdover_req` and `out_of_range` are all 1. With a good reference, `ref_fail` and `holdover_req` fall to 0 when that first gate ends.
- R2: `rate_sel` sets the nominal reference rate: code 0 is 2 kHz, 1 is 8 kHz, 2 is 1.544 MHz, 3 is 2.048 MHz, 4 is 8.192 MHz, 5 is 16.384 MHz and 6 is 19.44 MHz. Code 7 behaves as code 1. The nominal count is floor(GATE_CYC × f / MCLK_HZ).
- R3: At the end of a gate, if the absolute difference between the edge count and the nominal count exceeds floor(nominal × OUT_PPM / 10^6), `out_of_range` becomes 1.
- R4: At the end of a gate, if that difference is at most floor(nominal × IN_PPM / 10^6), `out_of_range` becomes 0.
- R5: If the difference lies strictly above the inner limit and at or below the outer limit, `out_of_range` keeps its previous value. It also changes at no time other than a gate end.
- R6: When no rising reference edge has been seen for floor(3 × MCLK_HZ / (2f)) master cycles, `ref_fail` and `holdover_req` assert without waiting for the gate to end.
- R7: When a gate's difference exceeds floor(nominal × COARSE_PPM / 10^6), `ref_fail` and `holdover_req` assert. They stay asserted at least until a later gate ends within that limit.
- R8: Once every fault has cleared, `ref_fail` stays 1 for REQ_CYC further fault-free cycles and then falls. Any new fault in that time restarts the interval.
- R9: `holdover_req` always equals `ref_fail`. An out-of-range condition alone raises neither of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Incoming timing reference, asynchronous to clk |
| rate_sel | input | 3 | Nominal reference rate code |
| ref_fail | output | 1 | Reference disqualified |
| out_of_range | output | 1 | Precise frequency offset outside the window, with hysteresis |
| holdover_req | output | 1 | Request for the loop to enter holdover |

## Verification
The flags decided at a gate end are due within one gate of the stimulus that causes them. Because a stimulus change can land anywhere inside the gate, the bench samples two full gates plus a small margin after every period or rate change, so the last completed gate has seen only the new stimulus. The missing-edge fault is due 1.5 nominal periods after the last edge, and the bench samples it 100 cycles into an outage. The requalify release is due REQ_CYC cycles after the fault clears, so the bench samples one point well before that and one point safely after it. The bench chooses reference periods whose edge count, rounded either way, stays on one side of every limit, so its arithmetic expectation does not depend on the phase of the gate.

// File: rtl/refmon.sv
module refmon #(
  parameter int MCLK_HZ    = 80_000_000,
  parameter int GATE_CYC   = 80_000_000,
  parameter int IN_PPM     = 64,
  parameter int OUT_PPM    = 83,
  parameter int COARSE_PPM = 10_000,
  parameter int REQ_CYC    = 800_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic [2:0] rate_sel,
  output logic       ref_fail,
  output logic       out_of_range,
  output logic       holdover_req
);
  localparam int CW = $clog2(GATE_CYC + 1);
  localparam int GW = $clog2(3 * (MCLK_HZ / 4000) + 4);
  localparam int TW = $clog2(REQ_CYC + 1);

  function automatic longint rate_hz(input int i);
    case (i)
      0: return 2_000;
      1: return 8_000;
      2: return 1_544_000;
      3: return 2_048_000;
      4: return 8_192_000;
      5: return 16_384_000;
      default: return 19_440_000;
    endcase
  endfunction

  function automatic longint nom_f(input int i);
    return longint'(GATE_CYC) * rate_hz(i) / longint'(MCLK_HZ);
  endfunction

  function automatic longint lim_f(input int i, input int ppm);
    return nom_f(i) * longint'(ppm) / 64'd1_000_000;
  endfunction

  function automatic longint gap_f(input int i);
    return (3 * longint'(MCLK_HZ)) / (2 * rate_hz(i));
  endfunction

  logic [CW-1:0] nom_t [7];
  logic [CW-1:0] inl_t [7];
  logic [CW-1:0] outl_t[7];
  logic [CW-1:0] crs_t [7];
  logic [GW-1:0] scf_t [7];

  for (genvar i = 0; i < 7; i++) begin : g_rate
    assign nom_t[i]  = CW'(nom_f(i));
    assign inl_t[i]  = CW'(lim_f(i, IN_PPM));
    assign outl_t[i] = CW'(lim_f(i, OUT_PPM));
    assign crs_t[i]  = CW'(lim_f(i, COARSE_PPM));
    assign scf_t[i]  = GW'(gap_f(i));
  end

  logic [2:0] si;
  assign si = (rate_sel == 3'd7) ? 3'd1 : rate_sel;

  logic [CW-1:0] nom, inl, outl, crs;
  logic [GW-1:0] scf;
  assign nom  = nom_t[si];
  assign inl  = inl_t[si];
  assign outl = outl_t[si];
  assign crs  = crs_t[si];
  assign scf  = scf_t[si];

  logic [2:0] sh;
  logic       edge_s;
  assign edge_s = sh[1] & ~sh[2];

  logic [CW-1:0] gcnt, ecnt, total, dev;
  logic          gate_end;
  assign gate_end = (gcnt == CW'(GATE_CYC - 1));
  assign total    = ecnt + CW'(edge_s);
  assign dev      = (total > nom) ? total - nom : nom - total;

  logic oor, coarse_q, primed;
  logic [GW-1:0] gap;
  logic miss, fault;
  logic [TW-1:0] tmr;

  assign miss  = (gap >= scf);
  assign fault = miss | coarse_q;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], ref_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt     <= '0;
      ecnt     <= '0;
      oor      <= 1'b1;
      coarse_q <= 1'b0;
      primed   <= 1'b0;
    end else begin
      gcnt <= gate_end ? '0 : gcnt + 1'b1;
      ecnt <= gate_end ? '0 : total;
      if (gate_end) begin
        primed   <= 1'b1;
        coarse_q <= (dev > crs);
        if (dev > outl)       oor <= 1'b1;
        else if (dev <= inl)  oor <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         gap <= '0;
    else if (edge_s) gap <= '0;
    else if (!miss)  gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             tmr <= '0;
    else if (fault)      tmr <= TW'(REQ_CYC);
    else if (tmr != '0)  tmr <= tmr - 1'b1;
  end

  assign ref_fail     = ~primed | fault | (tmr != '0);
  assign holdover_req = ref_fail;
  assign out_of_range = oor;
endmodule

module refmon_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          gate_end,
  input logic [CW-1:0] dev,
  input logic [CW-1:0] inl,
  input logic [CW-1:0] outl,
  input logic          out_of_range,
  input logic          ref_fail,
  input logic          miss,
  input logic          coarse_q
);
  a_r3_oor_set: assert property (@(posedge clk) disable iff (rst)
    gate_end && (dev > outl) |=> out_of_range);

  a_r4_oor_clear: assert property (@(posedge clk) disable iff (rst)
    gate_end && (dev <= inl) |=> !out_of_range);

  a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
    gate_end && (dev > inl) && (dev <= outl) |=> $stable(out_of_range));

  a_r5_no_midgate_change: assert property (@(posedge clk) disable iff (rst)
    !gate_end |=> $stable(out_of_range));

  a_r7_coarse_holds_fail: assert property (@(posedge clk) disable iff (rst)
    coarse_q && !gate_end |=> ref_fail);

  a_r8_release_after_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_fail) |-> !$past(miss) && !$past(coarse_q));
endmodule

bind refmon refmon_chk #(.CW(CW)) u_refmon_chk (
  .clk(clk), .rst(rst), .gate_end(gate_end), .dev(dev), .inl(inl), .outl(outl),
  .out_of_range(out_of_range), .ref_fail(ref_fail), .miss(miss), .coarse_q(coarse_q)
);

// File: tb/test_refmon.sv
module test_refmon;
  localparam int MHZ  = 50_000;
  localparam int GATE = 5_000;
  localparam int REQ  = 2_000;

  logic clk = 1'b0, rst = 1'b1, ref_in = 1'b0;
  logic [2:0] sel = 3'd0;
  logic ref_fail, out_of_range, holdover_req;

  int period = 25;
  bit run = 1'b1;
  int errors = 0, checks = 0;

  refmon #(.MCLK_HZ(MHZ), .GATE_CYC(GATE), .IN_PPM(50_000), .OUT_PPM(100_000),
           .COARSE_PPM(200_000), .REQ_CYC(REQ)) i_refmon (
    .clk(clk), .rst(rst), .ref_in(ref_in), .rate_sel(sel),
    .ref_fail(ref_fail), .out_of_range(out_of_range), .holdover_req(holdover_req));

  always #10 clk = ~clk;

  initial forever begin
    if (run) begin
      ref_in = 1'b1;
      repeat (period / 2) @(negedge clk);
      ref_in = 1'b0;
      repeat (period - period / 2) @(negedge clk);
    end else begin
      ref_in = 1'b0;
      @(negedge clk);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_oor(int p, int nomv, int inl, int outl, int prev);
    int cnt = GATE / p;
    int dev = (cnt > nomv) ? cnt - nomv : nomv - cnt;
    if (dev > outl) return 1;
    if (dev <= inl) return 0;
    return prev;
  endfunction

  function automatic string band_tag(int p, int nomv, int inl, int outl);
    int cnt = GATE / p;
    int dev = (cnt > nomv) ? cnt - nomv : nomv - cnt;
    if (dev > outl) return "R3 out-of-range set";
    if (dev <= inl) return "R4 in-range clear";
    return "R5 hysteresis hold";
  endfunction

  initial begin
    repeat (195_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int prev;
    int sweep[11] = '{25, 23, 22, 23, 24, 27, 28, 27, 26, 21, 25};
    wait_n(5);
    chk("R1 fail during reset", ref_fail, 1'b1);
    rst = 1'b0;
    wait_n(100);
    chk("R1 fail before first gate", ref_fail, 1'b1);
    chk("R1 holdover before first gate", holdover_req, 1'b1);
    chk("R1 oor before first gate", out_of_range, 1'b1);
    wait_n(4800);
    chk("R1 fail just before gate end", ref_fail, 1'b1);
    wait_n(200);
    chk("R1 fail released after first gate", ref_fail, 1'b0);
    chk("R1 holdover released after first gate", holdover_req, 1'b0);
    chk("R4 oor cleared after first gate", out_of_range, 1'b0);

    // sweep of 2 kHz periods: nominal 200 edges, limits 10 / 20 / 40
    prev = 0;
    foreach (sweep[k]) begin
      int e;
      period = sweep[k];
      wait_n(2 * GATE + 50);
      e = exp_oor(sweep[k], 200, 10, 20, prev);
      chk(band_tag(sweep[k], 200, 10, 20), out_of_range, e[0]);
      chk("R9 oor alone keeps fail low", ref_fail, 1'b0);
      chk("R9 oor alone keeps holdover low", holdover_req, 1'b0);
      prev = e;
    end

    // R6: reference stops toggling
    run = 1'b0;
    wait_n(100);
    chk("R6 missing edge fail", ref_fail, 1'b1);
    chk("R6 missing edge holdover", holdover_req, 1'b1);
    wait_n(100);
    run = 1'b1;
    wait_n(1500);
    chk("R8 fail held during requalify", ref_fail, 1'b1);
    chk("R9 holdover follows fail", holdover_req, 1'b1);
    wait_n(700);
    chk("R8 fail released after requalify", ref_fail, 1'b0);
    chk("R9 holdover released with fail", holdover_req, 1'b0);

    // R7: gross frequency error (250 edges vs 200)
    period = 20;
    wait_n(2 * GATE + 50);
    chk("R7 coarse fail", ref_fail, 1'b1);
    chk("R7 coarse holdover", holdover_req, 1'b1);
    chk("R3 coarse also out of range", out_of_range, 1'b1);
    period = 25;
    wait_n(1500);
    chk("R8 coarse fail still held", ref_fail, 1'b1);
    wait_n(2 * GATE + 700);
    chk("R8 coarse fail released", ref_fail, 1'b0);
    chk("R4 back in range", out_of_range, 1'b0);

    // R2: 8 kHz code, nominal 800 edges, limits 40 / 80 / 160
    sel = 3'd1;
    period = 6;
    wait_n(2 * GATE + 2200);
    chk("R2 8k code period 6 in range", out_of_range, 1'b0);
    chk("R2 8k code period 6 no fail", ref_fail, 1'b0);
    period = 7;
    wait_n(2 * GATE + 50);
    chk("R2 8k code period 7 out of range", out_of_range, 1'b1);
    chk("R2 8k code period 7 no fail", ref_fail, 1'b0);
    sel = 3'd7;
    wait_n(GATE + 100);
    chk("R2 code 7 acts as 8k, no fail", ref_fail, 1'b0);
    chk("R2 code 7 acts as 8k, oor kept", out_of_range, 1'b1);

    summary();
    $finish;
  end
endmodule